// File: doc/BRIEF.md
# Floating-Point Coprocessor Operand Decoder

This block sits between the coprocessor's transfer sequencer and its register file. It takes the identification byte that announced an instruction and the 16-bit operation word that followed it. From them it works out how many bytes each of the two source operands occupies and how many bytes the result occupies. It also reports which of those values live in the eight-entry 32-bit floating-point register file, which register indices are involved, and a nominal execution time in clock cycles.

Two instruction groups are recognised. The conversion/control group is introduced by ID byte 0x3E and covers integer/float moves, precision changes, status load and store, and float-to-integer rounding. The arithmetic group is introduced by ID byte 0xBE and covers add, move, compare, subtract, negate, divide, multiply and absolute value. Any other ID byte leaves every output inactive. The decode is one-stage registered: the outputs describe the ID byte and operation word present at the previous rising clock edge. The sequencer uses the byte counts to know how many 16-bit operand and result words to transfer. The register-access logic uses the in-register flags and indices. A double-precision register value spans the named register and its partner (index XOR 1), and the partner holds the upper 32 bits.

Top module: `fpu_opdec`

## Requirements
- R1: While rst_ni is low every output is zero, including the register indices and the cycle estimate.
- R2: Outputs reflect id_i and opword_i sampled at the preceding rising edge of clk_i. match_o is 1 only for ID 0x3E or 0xBE. Any other ID gives zero byte counts, cleared flags, illegal_o 0 and cycles_o 0.
- R3: For ID 0x3E the opcode is opword bits 5:3 and float length is 4 when bit 2 is 1, else 8. Opcode 1 reads 4 bytes and writes none. Opcode 6 reads none and writes 4. Opcode 2 reads 8 and opcode 3 reads 4, both writing the float length. src2_bytes_o is always 0.
- R4: For ID 0x3E the integer length is opword bits 1:0 plus one. Opcode 0 reads that many bytes and writes the float length. Opcodes 4, 5 and 7 read the float length and write the integer length.
- R5: For ID 0xBE the opcode is opword bits 5:2 and float length is 4 when bit 0 is 1, else 8. Defined opcodes (0,1,2,4,5,8,12,13) read the float length as source 1. Even ones also read it as source 2. All except 2 (compare) write the float length.
- R6: For ID 0xBE, opcodes 3,6,7,9,10,11,14,15 set illegal_o, give zero byte counts, cleared in-register flags and cycles_o 0.
- R7: src1_in_reg_o is 1 when source 1 has a nonzero count and opword bits 15:14 are 00, except for ID 0x3E opcodes 0 and 1. src1_reg_o is opword bits 13:11 and src1_pair_o is that index XOR 1.
- R8: When opword bits 10:9 are 00, src2_in_reg_o follows a nonzero source-2 count and res_in_reg_o follows a nonzero result count. res_in_reg_o stays 0 for ID 0x3E opcodes 4 to 7. dst_reg_o is bits 8:6 and dst_pair_o is that index XOR 1.
- R9: ID 0x3E cycles: opcode 0 53, 1 18, 6 13. Opcode 2 is 23 when bits 15:14 are nonzero, else 27. Opcode 3 is 22/26 on the same rule. Opcodes 4, 5 and 7 are 53/66 on the same rule.
- R10: ID 0xBE cycles, where "any" means bits 15:14 or 10:9 are nonzero. Add and subtract give 70 with any set, else 74. Compare gives 45/49. Move gives 23/27 and negate and absolute give 20/24, both chosen by bits 15:14 alone. Multiply is 30/34 plus 14 (single) or 28 (double). Divide is 55/59 plus 30 or 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_i | input | 8 | Identification byte of the current instruction |
| opword_i | input | 16 | Operation word, already in decode bit order |
| match_o | output | 1 | ID byte names a recognised group |
| illegal_o | output | 1 | Undefined arithmetic opcode |
| src1_bytes_o | output | 4 | Byte length of source operand 1 |
| src2_bytes_o | output | 4 | Byte length of source operand 2 |
| res_bytes_o | output | 4 | Byte length of the result |
| src1_in_reg_o | output | 1 | Source 1 is read from the register file |
| src2_in_reg_o | output | 1 | Source 2 is read from the register file |
| res_in_reg_o | output | 1 | Result is written back to the register file |
| src1_reg_o | output | 3 | Register index for source 1 |
| src1_pair_o | output | 3 | Partner register holding source 1's upper half |
| dst_reg_o | output | 3 | Register index for source 2 and the result |
| dst_pair_o | output | 3 | Partner register holding the upper half |
| cycles_o | output | 8 | Estimated execution cycles |

## Verification
Source-1 register read and result write-back can both be active for the same word. Both address fields zero in a double-precision arithmetic instruction makes the block report two register pairs, plus a cycle figure that depends on both fields, in one output cycle. The bench drives such words back to back with others that differ only in one addressing field. It judges each cycle against a model built from the requirements. Undefined opcodes with zero addressing fields also collide with register access, and the bench checks that the illegal flag clears every access flag in that same cycle.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
  parameter int OPW_W  = 16;
  parameter int ID_W   = 8;
  parameter int BYTE_W = 4;
  parameter int CYC_W  = 8;
  parameter int FREG_W = 3;

  localparam logic [ID_W-1:0]   ID_CONV  = 8'h3E;
  localparam logic [ID_W-1:0]   ID_ARITH = 8'hBE;
  localparam logic [BYTE_W-1:0] LEN_SGL  = BYTE_W'(4);
  localparam logic [BYTE_W-1:0] LEN_DBL  = BYTE_W'(8);

  typedef struct packed {
    logic                match;
    logic                illegal;
    logic [BYTE_W-1:0]   s1_bytes;
    logic [BYTE_W-1:0]   s2_bytes;
    logic [BYTE_W-1:0]   res_bytes;
    logic                s1_reg;
    logic                s2_reg;
    logic                res_reg;
    logic [FREG_W-1:0]   s1_idx;
    logic [FREG_W-1:0]   s1_pair;
    logic [FREG_W-1:0]   d_idx;
    logic [FREG_W-1:0]   d_pair;
    logic [CYC_W-1:0]    cycles;
  } dec_t;
endpackage

// File: rtl/fpdec_conv.sv
module fpdec_conv
  import fpdec_pkg::*;
(
  input  logic [OPW_W-1:0]  opword_i,
  output logic [BYTE_W-1:0] s1_bytes_o,
  output logic [BYTE_W-1:0] res_bytes_o,
  output logic              s1_fp_o,
  output logic              res_fp_o,
  output logic [CYC_W-1:0]  cycles_o
);
  logic [2:0]        op;
  logic [BYTE_W-1:0] flen;
  logic [BYTE_W-1:0] ilen;
  logic              mem1;

  assign op   = opword_i[5:3];
  assign flen = opword_i[2] ? LEN_SGL : LEN_DBL;
  assign ilen = BYTE_W'(opword_i[1:0]) + BYTE_W'(1);
  assign mem1 = |opword_i[15:14];

  always_comb begin
    s1_bytes_o  = '0;
    res_bytes_o = '0;
    cycles_o    = '0;
    unique case (op)
      3'd0: begin s1_bytes_o = ilen;    res_bytes_o = flen; cycles_o = CYC_W'(53); end
      3'd1: begin s1_bytes_o = LEN_SGL;                     cycles_o = CYC_W'(18); end
      3'd2: begin s1_bytes_o = LEN_DBL; res_bytes_o = flen; cycles_o = mem1 ? CYC_W'(23) : CYC_W'(27); end
      3'd3: begin s1_bytes_o = LEN_SGL; res_bytes_o = flen; cycles_o = mem1 ? CYC_W'(22) : CYC_W'(26); end
      3'd6: begin                       res_bytes_o = LEN_SGL; cycles_o = CYC_W'(13); end
      default: begin // round, truncate, floor
        s1_bytes_o  = flen;
        res_bytes_o = ilen;
        cycles_o    = mem1 ? CYC_W'(53) : CYC_W'(66);
      end
    endcase
  end

  // integer sources and integer results never touch the float file
  assign s1_fp_o  = (op > 3'd1);
  assign res_fp_o = (op < 3'd4);
endmodule

// File: rtl/fpdec_arith.sv
module fpdec_arith
  import fpdec_pkg::*;
(
  input  logic [OPW_W-1:0]  opword_i,
  output logic [BYTE_W-1:0] s1_bytes_o,
  output logic [BYTE_W-1:0] s2_bytes_o,
  output logic [BYTE_W-1:0] res_bytes_o,
  output logic              illegal_o,
  output logic [CYC_W-1:0]  cycles_o
);
  logic [3:0]        op;
  logic              sgl;
  logic [BYTE_W-1:0] flen;
  logic              mem1;
  logic              any_mem;
  logic              defined;

  assign op      = opword_i[5:2];
  assign sgl     = opword_i[0];
  assign flen    = sgl ? LEN_SGL : LEN_DBL;
  assign mem1    = |opword_i[15:14];
  assign any_mem = mem1 | (|opword_i[10:9]);

  always_comb begin
    defined  = 1'b1;
    cycles_o = '0;
    unique case (op)
      4'd0, 4'd4: cycles_o = any_mem ? CYC_W'(70) : CYC_W'(74);
      4'd1:       cycles_o = mem1 ? CYC_W'(23) : CYC_W'(27);
      4'd2:       cycles_o = any_mem ? CYC_W'(45) : CYC_W'(49);
      4'd5, 4'd13: cycles_o = mem1 ? CYC_W'(20) : CYC_W'(24);
      4'd8:  cycles_o = (any_mem ? CYC_W'(55) : CYC_W'(59)) + (sgl ? CYC_W'(30) : CYC_W'(60));
      4'd12: cycles_o = (any_mem ? CYC_W'(30) : CYC_W'(34)) + (sgl ? CYC_W'(14) : CYC_W'(28));
      default: defined = 1'b0;
    endcase
  end

  assign illegal_o   = ~defined;
  assign s1_bytes_o  = defined ? flen : '0;
  assign s2_bytes_o  = (defined && !op[0]) ? flen : '0;
  assign res_bytes_o = (defined && op != 4'd2) ? flen : '0;
endmodule

// File: rtl/fpdec_regsel.sv
module fpdec_regsel
  import fpdec_pkg::*;
(
  input  logic [OPW_W-1:0]  opword_i,
  input  logic [BYTE_W-1:0] s1_bytes_i,
  input  logic [BYTE_W-1:0] s2_bytes_i,
  input  logic [BYTE_W-1:0] res_bytes_i,
  input  logic              s1_fp_i,
  input  logic              res_fp_i,
  output logic              s1_reg_o,
  output logic              s2_reg_o,
  output logic              res_reg_o,
  output logic [FREG_W-1:0] s1_idx_o,
  output logic [FREG_W-1:0] s1_pair_o,
  output logic [FREG_W-1:0] d_idx_o,
  output logic [FREG_W-1:0] d_pair_o
);
  localparam int NFIELD = 2;
  // field 0: source 1 (mode 15:14, index 13:11); field 1: source 2/result (mode 10:9, index 8:6)
  localparam int IDX_LSB [NFIELD] = '{11, 6};
  localparam int MOD_LSB [NFIELD] = '{14, 9};

  logic [NFIELD-1:0]       is_reg;
  logic [FREG_W-1:0]       idx  [NFIELD];
  logic [FREG_W-1:0]       pair [NFIELD];

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    assign is_reg[g] = ~|opword_i[MOD_LSB[g] +: 2];
    assign idx[g]    = opword_i[IDX_LSB[g] +: FREG_W];
    assign pair[g]   = idx[g] ^ FREG_W'(1);
  end

  assign s1_reg_o  = is_reg[0] && s1_fp_i && (s1_bytes_i != '0);
  assign s2_reg_o  = is_reg[1] && (s2_bytes_i != '0);
  assign res_reg_o = is_reg[1] && res_fp_i && (res_bytes_i != '0);
  assign s1_idx_o  = idx[0];
  assign s1_pair_o = pair[0];
  assign d_idx_o   = idx[1];
  assign d_pair_o  = pair[1];
endmodule

// File: rtl/fpu_opdec.sv
module fpu_opdec
  import fpdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   id_i,
  input  logic [OPW_W-1:0]  opword_i,
  output logic              match_o,
  output logic              illegal_o,
  output logic [BYTE_W-1:0] src1_bytes_o,
  output logic [BYTE_W-1:0] src2_bytes_o,
  output logic [BYTE_W-1:0] res_bytes_o,
  output logic              src1_in_reg_o,
  output logic              src2_in_reg_o,
  output logic              res_in_reg_o,
  output logic [FREG_W-1:0] src1_reg_o,
  output logic [FREG_W-1:0] src1_pair_o,
  output logic [FREG_W-1:0] dst_reg_o,
  output logic [FREG_W-1:0] dst_pair_o,
  output logic [CYC_W-1:0]  cycles_o
);
  logic is_conv, is_arith;
  assign is_conv  = (id_i == ID_CONV);
  assign is_arith = (id_i == ID_ARITH);

  logic [BYTE_W-1:0] c_s1, c_res, a_s1, a_s2, a_res;
  logic              c_s1_fp, c_res_fp, a_ill;
  logic [CYC_W-1:0]  c_cyc, a_cyc;

  fpdec_conv u_conv (
    .opword_i    (opword_i),
    .s1_bytes_o  (c_s1),
    .res_bytes_o (c_res),
    .s1_fp_o     (c_s1_fp),
    .res_fp_o    (c_res_fp),
    .cycles_o    (c_cyc)
  );

  fpdec_arith u_arith (
    .opword_i    (opword_i),
    .s1_bytes_o  (a_s1),
    .s2_bytes_o  (a_s2),
    .res_bytes_o (a_res),
    .illegal_o   (a_ill),
    .cycles_o    (a_cyc)
  );

  logic [BYTE_W-1:0] m_s1, m_s2, m_res;
  logic              m_s1_fp, m_res_fp, m_ill;
  logic [CYC_W-1:0]  m_cyc;

  always_comb begin
    m_s1 = '0; m_s2 = '0; m_res = '0;
    m_s1_fp = 1'b0; m_res_fp = 1'b0; m_ill = 1'b0; m_cyc = '0;
    if (is_conv) begin
      m_s1 = c_s1; m_res = c_res; m_s1_fp = c_s1_fp; m_res_fp = c_res_fp; m_cyc = c_cyc;
    end else if (is_arith) begin
      m_s1 = a_s1; m_s2 = a_s2; m_res = a_res; m_s1_fp = 1'b1; m_res_fp = 1'b1;
      m_ill = a_ill; m_cyc = a_cyc;
    end
  end

  dec_t nxt, cur;

  fpdec_regsel u_regsel (
    .opword_i    (opword_i),
    .s1_bytes_i  (m_s1),
    .s2_bytes_i  (m_s2),
    .res_bytes_i (m_res),
    .s1_fp_i     (m_s1_fp),
    .res_fp_i    (m_res_fp),
    .s1_reg_o    (nxt.s1_reg),
    .s2_reg_o    (nxt.s2_reg),
    .res_reg_o   (nxt.res_reg),
    .s1_idx_o    (nxt.s1_idx),
    .s1_pair_o   (nxt.s1_pair),
    .d_idx_o     (nxt.d_idx),
    .d_pair_o    (nxt.d_pair)
  );

  assign nxt.match     = is_conv | is_arith;
  assign nxt.illegal   = m_ill;
  assign nxt.s1_bytes  = m_s1;
  assign nxt.s2_bytes  = m_s2;
  assign nxt.res_bytes = m_res;
  assign nxt.cycles    = m_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur <= '0;
    else         cur <= nxt;
  end

  assign match_o       = cur.match;
  assign illegal_o     = cur.illegal;
  assign src1_bytes_o  = cur.s1_bytes;
  assign src2_bytes_o  = cur.s2_bytes;
  assign res_bytes_o   = cur.res_bytes;
  assign src1_in_reg_o = cur.s1_reg;
  assign src2_in_reg_o = cur.s2_reg;
  assign res_in_reg_o  = cur.res_reg;
  assign src1_reg_o    = cur.s1_idx;
  assign src1_pair_o   = cur.s1_pair;
  assign dst_reg_o     = cur.d_idx;
  assign dst_pair_o    = cur.d_pair;
  assign cycles_o      = cur.cycles;
endmodule

// File: rtl/fpu_opdec_chk.sv
module fpu_opdec_chk
  import fpdec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ID_W-1:0]   id_i,
  input logic [OPW_W-1:0]  opword_i,
  input logic              match_o,
  input logic              illegal_o,
  input logic [BYTE_W-1:0] src1_bytes_o,
  input logic [BYTE_W-1:0] src2_bytes_o,
  input logic [BYTE_W-1:0] res_bytes_o,
  input logic              src1_in_reg_o,
  input logic              src2_in_reg_o,
  input logic              res_in_reg_o,
  input logic [CYC_W-1:0]  cycles_o
);
  p_unmatched_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_i != ID_CONV && id_i != ID_ARITH) |=>
      (!match_o && !illegal_o && src1_bytes_o == '0 && src2_bytes_o == '0 &&
       res_bytes_o == '0 && cycles_o == '0));

  p_conv_no_src2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_i == ID_CONV) |=> (src2_bytes_o == '0 && !src2_in_reg_o && !illegal_o));

  p_cmp_no_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_i == ID_ARITH && opword_i[5:2] == 4'd2) |=>
      (res_bytes_o == '0 && !res_in_reg_o && src2_bytes_o != '0));

  p_illegal_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (src1_bytes_o == '0 && src2_bytes_o == '0 && res_bytes_o == '0 &&
                   !src1_in_reg_o && !src2_in_reg_o && !res_in_reg_o && cycles_o == '0));

  p_int_src_mem_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_i == ID_CONV && opword_i[5:4] == 2'b00) |=> !src1_in_reg_o);

  p_int_res_no_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_i == ID_CONV && opword_i[5]) |=> !res_in_reg_o);

  p_mem_field_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opword_i[10:9] != 2'b00) |=> (!src2_in_reg_o && !res_in_reg_o));

  p_reg_needs_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_in_reg_o |-> (res_bytes_o != '0 && match_o));
endmodule

bind fpu_opdec fpu_opdec_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .id_i          (id_i),
  .opword_i      (opword_i),
  .match_o       (match_o),
  .illegal_o     (illegal_o),
  .src1_bytes_o  (src1_bytes_o),
  .src2_bytes_o  (src2_bytes_o),
  .res_bytes_o   (res_bytes_o),
  .src1_in_reg_o (src1_in_reg_o),
  .src2_in_reg_o (src2_in_reg_o),
  .res_in_reg_o  (res_in_reg_o),
  .cycles_o      (cycles_o)
);

// File: tb/fpu_opdec_test.sv
`timescale 1ns/1ps
module fpu_opdec_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  id_i = 8'hBE;
  logic [15:0] opword_i = 16'h0000;
  logic        match_o, illegal_o, src1_in_reg_o, src2_in_reg_o, res_in_reg_o;
  logic [3:0]  src1_bytes_o, src2_bytes_o, res_bytes_o;
  logic [2:0]  src1_reg_o, src1_pair_o, dst_reg_o, dst_pair_o;
  logic [7:0]  cycles_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fpu_opdec uut (
    .clk_i(clk), .rst_ni(rst_ni), .id_i(id_i), .opword_i(opword_i),
    .match_o(match_o), .illegal_o(illegal_o),
    .src1_bytes_o(src1_bytes_o), .src2_bytes_o(src2_bytes_o), .res_bytes_o(res_bytes_o),
    .src1_in_reg_o(src1_in_reg_o), .src2_in_reg_o(src2_in_reg_o), .res_in_reg_o(res_in_reg_o),
    .src1_reg_o(src1_reg_o), .src1_pair_o(src1_pair_o),
    .dst_reg_o(dst_reg_o), .dst_pair_o(dst_pair_o), .cycles_o(cycles_o)
  );

  typedef struct { logic [36:0] exp; string tag; } item_t;
  item_t sb[$];

  function automatic logic [36:0] actual();
    return {match_o, illegal_o, src1_bytes_o, src2_bytes_o, res_bytes_o,
            src1_in_reg_o, src2_in_reg_o, res_in_reg_o,
            src1_reg_o, src1_pair_o, dst_reg_o, dst_pair_o, cycles_o};
  endfunction

  // Reference built from the requirement list
  function automatic logic [36:0] model(input logic [7:0] id, input logic [15:0] w);
    logic m, il, f1, f2, fr, mem1, anym;
    logic [3:0] s1, s2, r, fl, isz;
    logic [7:0] cyc;
    m = (id == 8'h3E) || (id == 8'hBE);
    il = 0; f1 = 0; f2 = 0; fr = 0; s1 = 0; s2 = 0; r = 0; cyc = 0;
    mem1 = (w[15:14] != 0);
    anym = mem1 || (w[10:9] != 0);
    isz  = {2'b00, w[1:0]} + 4'd1;
    if (id == 8'h3E) begin
      fl = w[2] ? 4'd4 : 4'd8;
      case (w[5:3])
        0: begin s1 = isz; r = fl; cyc = 53; end
        1: begin s1 = 4; cyc = 18; end
        2: begin s1 = 8; r = fl; cyc = mem1 ? 23 : 27; end
        3: begin s1 = 4; r = fl; cyc = mem1 ? 22 : 26; end
        6: begin r = 4; cyc = 13; end
        default: begin s1 = fl; r = isz; cyc = mem1 ? 53 : 66; end
      endcase
      f1 = (w[5:3] >= 2) && (s1 != 0) && !mem1;
      fr = (w[5:3] < 4) && (r != 0) && (w[10:9] == 0);
    end else if (id == 8'hBE) begin
      fl = w[0] ? 4'd4 : 4'd8;
      case (w[5:2])
        0, 4: begin s1 = fl; s2 = fl; r = fl; cyc = anym ? 70 : 74; end
        1:    begin s1 = fl; r = fl; cyc = mem1 ? 23 : 27; end
        2:    begin s1 = fl; s2 = fl; cyc = anym ? 45 : 49; end
        5, 13: begin s1 = fl; r = fl; cyc = mem1 ? 20 : 24; end
        8:  begin s1 = fl; s2 = fl; r = fl; cyc = (anym ? 8'd55 : 8'd59) + (w[0] ? 8'd30 : 8'd60); end
        12: begin s1 = fl; s2 = fl; r = fl; cyc = (anym ? 8'd30 : 8'd34) + (w[0] ? 8'd14 : 8'd28); end
        default: il = 1;
      endcase
      f1 = (s1 != 0) && !mem1;
      f2 = (s2 != 0) && (w[10:9] == 0);
      fr = (r != 0) && (w[10:9] == 0);
    end
    return {m, il, s1, s2, r, f1, f2, fr, w[13:11], w[13:11] ^ 3'd1, w[8:6], w[8:6] ^ 3'd1, cyc};
  endfunction

  function automatic logic [15:0] ow(input logic [1:0] m1, input logic [2:0] r1,
                                     input logic [1:0] m2, input logic [2:0] r2,
                                     input logic [5:0] lo);
    return {m1, r1, m2, r2, lo};
  endfunction

  // conversion low bits: opcode, single, size
  function automatic logic [5:0] cv(input logic [2:0] op, input logic sg, input logic [1:0] sz);
    return {op, sg, sz};
  endfunction
  // arithmetic low bits: opcode, 0, single
  function automatic logic [5:0] ar(input logic [3:0] op, input logic sg);
    return {op, 1'b0, sg};
  endfunction

  task automatic drive(input logic [7:0] id, input logic [15:0] w, input string tag);
    item_t it;
    @(negedge clk);
    id_i = id;
    opword_i = w;
    it.exp = model(id, w);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: each pushed item is captured at the next rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (actual() !== it.exp) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", it.tag, actual(), it.exp);
      end
    end
  end

  initial begin : wdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    opword_i = ow(2'b00, 3'd2, 2'b00, 3'd5, ar(4'd0, 1'b0));
    repeat (3) @(posedge clk);
    #3;
    checks++; // R1 reset state
    if (actual() !== 37'd0) begin
      errors++;
      $display("FAIL R1 act=%h exp=%h", actual(), 37'd0);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    // R3 / R4 / R9 conversion group
    drive(8'h3E, ow(2'b01, 3'd1, 2'b00, 3'd3, cv(3'd0, 1'b1, 2'd0)), "R4");
    drive(8'h3E, ow(2'b00, 3'd1, 2'b00, 3'd3, cv(3'd0, 1'b0, 2'd1)), "R4");
    drive(8'h3E, ow(2'b00, 3'd4, 2'b00, 3'd2, cv(3'd0, 1'b0, 2'd3)), "R7");
    drive(8'h3E, ow(2'b00, 3'd0, 2'b00, 3'd0, cv(3'd1, 1'b0, 2'd0)), "R3");
    drive(8'h3E, ow(2'b00, 3'd6, 2'b00, 3'd7, cv(3'd2, 1'b1, 2'd0)), "R9");
    drive(8'h3E, ow(2'b10, 3'd6, 2'b00, 3'd7, cv(3'd2, 1'b1, 2'd0)), "R9");
    drive(8'h3E, ow(2'b00, 3'd3, 2'b11, 3'd1, cv(3'd3, 1'b0, 2'd0)), "R3");
    drive(8'h3E, ow(2'b11, 3'd3, 2'b00, 3'd1, cv(3'd3, 1'b0, 2'd0)), "R9");
    drive(8'h3E, ow(2'b00, 3'd5, 2'b00, 3'd4, cv(3'd4, 1'b1, 2'd1)), "R8");
    drive(8'h3E, ow(2'b01, 3'd5, 2'b00, 3'd4, cv(3'd5, 1'b0, 2'd3)), "R4");
    drive(8'h3E, ow(2'b00, 3'd0, 2'b00, 3'd6, cv(3'd6, 1'b0, 2'd0)), "R3");
    drive(8'h3E, ow(2'b00, 3'd7, 2'b00, 3'd1, cv(3'd7, 1'b1, 2'd0)), "R4");
    // R5 / R10 arithmetic group, register/memory mixes back to back
    drive(8'hBE, ow(2'b00, 3'd2, 2'b00, 3'd5, ar(4'd0, 1'b0)), "R7");
    drive(8'hBE, ow(2'b00, 3'd2, 2'b01, 3'd5, ar(4'd0, 1'b0)), "R10");
    drive(8'hBE, ow(2'b10, 3'd2, 2'b00, 3'd5, ar(4'd4, 1'b1)), "R10");
    drive(8'hBE, ow(2'b00, 3'd1, 2'b10, 3'd0, ar(4'd1, 1'b1)), "R8");
    drive(8'hBE, ow(2'b00, 3'd4, 2'b00, 3'd6, ar(4'd2, 1'b0)), "R5");
    drive(8'hBE, ow(2'b00, 3'd4, 2'b11, 3'd6, ar(4'd2, 1'b1)), "R10");
    drive(8'hBE, ow(2'b01, 3'd7, 2'b00, 3'd3, ar(4'd5, 1'b0)), "R5");
    drive(8'hBE, ow(2'b00, 3'd7, 2'b00, 3'd3, ar(4'd13, 1'b1)), "R10");
    drive(8'hBE, ow(2'b00, 3'd0, 2'b00, 3'd1, ar(4'd8, 1'b1)), "R10");
    drive(8'hBE, ow(2'b00, 3'd0, 2'b00, 3'd1, ar(4'd8, 1'b0)), "R10");
    drive(8'hBE, ow(2'b00, 3'd5, 2'b10, 3'd2, ar(4'd12, 1'b1)), "R10");
    drive(8'hBE, ow(2'b00, 3'd5, 2'b00, 3'd2, ar(4'd12, 1'b0)), "R10");
    // R6 undefined opcodes with register-mode fields
    for (int k = 0; k < 16; k++) begin
      drive(8'hBE, ow(2'b00, 3'(k), 2'b00, 3'(k + 3), ar(4'(k), k[0])), "R6");
    end
    // R2 unrecognised IDs
    drive(8'h12, ow(2'b00, 3'd2, 2'b00, 3'd5, ar(4'd0, 1'b0)), "R2");
    drive(8'h3F, ow(2'b00, 3'd2, 2'b00, 3'd5, cv(3'd3, 1'b0, 2'd0)), "R2");
    drive(8'hBE, ow(2'b00, 3'd2, 2'b00, 3'd5, ar(4'd0, 1'b1)), "R2");
    drive(8'h00, 16'h0000, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule